// File: doc/BRIEF.md
# Bidirectional GPIO Port with Open-Drain Outputs

This block controls a bank of general-purpose pins (16 by default). For each pin it holds a direction bit, an output latch bit and an open-drain select bit. From these it works out a pad drive value and a pad output enable for an external pad model. The levels coming back from the pads pass through a two-flop synchronizer before software can read them.

A small register bus reaches four word-wide registers: direction at address 0, latch at address 1, open-drain select at address 2 and port at address 3. A write to either the latch address or the port address stores the data in the output latch. A read of the port address returns the synchronized pad levels, and a read of the latch address returns the stored latch value. This split lets software avoid the read-modify-write hazard that appears when a loaded pin reads back different from what was written.

When a pin is an output in open-drain mode, it only ever pulls low. It releases the pad, with no drive, whenever its latch bit is 1. Bus accesses take one cycle. Read data is registered and holds its last value between reads.

Top module: `gpio_port`

## Requirements
- R1: After reset, reads return all ones for the direction register (address 0), zero for the latch register (address 1) and zero for the open-drain register (address 2).
- R2: A pin whose direction bit is 1 is an input: its output enable is 0 and its drive value is 0.
- R3: A pin whose direction bit is 0 and open-drain bit is 0 is a push-pull output: its output enable is 1 and its drive value equals its latch bit.
- R4: A pin whose direction bit is 0 and open-drain bit is 1 is an open-drain output: its drive value is 0 and its output enable is the inverse of its latch bit.
- R5: The open-drain bit has no effect on the pad outputs of a pin whose direction bit is 1.
- R6: A write to address 3 (port) or to address 1 (latch) stores the write data in the output latch, and a later read of address 1 returns it.
- R7: A read of address 3 returns each pad level as it stood two clock edges before the read edge. A read of address 1 returns the latch and never the pad level.
- R8: Read data appears on the read data output at the clock edge that accepts the read, and holds its value while no read is accepted.
- R9: A write takes effect at the clock edge that accepts it. Pad outputs keep their old values until that edge and show the new values straight after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access request for this cycle |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 2 | Register select: 0 direction, 1 latch, 2 open-drain, 3 port |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Registered read data |
| padIn | input | 16 | Levels seen at the pads |
| padOut | output | 16 | Value driven onto each pad |
| padOe | output | 16 | Output enable for each pad |

## Verification
Pad drive and enable follow the registers combinationally, so they change at the edge that accepts a write. The bench samples them at the falling edge just after that edge, and also once before it to show that nothing changed early. Read data is captured at the edge that accepts the read and is checked at the following falling edge. A pad level changed at a falling edge reaches the synchronizer output after two rising edges, so the bench waits out those two edges before it issues a port read. The bench then sweeps many direction, open-drain and latch patterns, plus every uniform combination of the three, and computes the expected enable and drive bit by bit.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    REG_DIR = 2'd0,
    REG_LAT = 2'd1,
    REG_ODC = 2'd2,
    REG_PIN = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrDir;
    logic    wrLat;
    logic    wrOdc;
    logic    rdEn;
    regSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strobe
);

  regSel_e addrSel;
  logic    wrReq;

  assign addrSel = regSel_e'(busAddr[1:0]);
  assign wrReq   = busSel & busWrite;

  always_comb begin
    strobe       = '0;
    strobe.rdEn  = busSel & ~busWrite;
    strobe.rdSel = addrSel;
    if (wrReq) begin
      unique case (addrSel)
        REG_DIR: strobe.wrDir = 1'b1;
        REG_LAT,
        REG_PIN: strobe.wrLat = 1'b1;   // port writes land in the latch
        REG_ODC: strobe.wrOdc = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int PIN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [PIN_W-1:0] wrData,
  input  logic [PIN_W-1:0] padIn,
  output logic [PIN_W-1:0] rdData,
  output logic [PIN_W-1:0] padOut,
  output logic [PIN_W-1:0] padOe,
  output logic [PIN_W-1:0] latState,
  output logic [PIN_W-1:0] pinSync
);

  logic [PIN_W-1:0] dirQ;
  logic [PIN_W-1:0] latQ;
  logic [PIN_W-1:0] odcQ;
  logic [PIN_W-1:0] metaQ;
  logic [PIN_W-1:0] syncQ;
  logic [PIN_W-1:0] rdNext;
  logic [PIN_W-1:0] rdQ;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ <= '1;
      latQ <= '0;
      odcQ <= '0;
    end else begin
      if (strobe.wrDir) dirQ <= wrData;
      if (strobe.wrLat) latQ <= wrData;
      if (strobe.wrOdc) odcQ <= wrData;
    end
  end

  // two-flop input synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      metaQ <= '0;
      syncQ <= '0;
    end else begin
      metaQ <= padIn;
      syncQ <= metaQ;
    end
  end

  // read path
  always_comb begin
    unique case (strobe.rdSel)
      REG_DIR: rdNext = dirQ;
      REG_LAT: rdNext = latQ;
      REG_ODC: rdNext = odcQ;
      REG_PIN: rdNext = syncQ;
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdQ <= '0;
    else if (strobe.rdEn) rdQ <= rdNext;
  end

  // per-pin pad driver
  for (genvar p = 0; p < PIN_W; p++) begin : g_pad
    logic isOut;
    assign isOut     = ~dirQ[p];
    assign padOe[p]  = isOut & (odcQ[p] ? ~latQ[p] : 1'b1);
    assign padOut[p] = isOut & ~odcQ[p] & latQ[p];
  end

  assign rdData   = rdQ;
  assign latState = latQ;
  assign pinSync  = syncQ;

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int PIN_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PIN_W-1:0]  busWdata,
  output logic [PIN_W-1:0]  busRdata,
  input  logic [PIN_W-1:0]  padIn,
  output logic [PIN_W-1:0]  padOut,
  output logic [PIN_W-1:0]  padOe
);

  ctrlStrobe_t      strobe;
  logic [PIN_W-1:0] latState;
  logic [PIN_W-1:0] pinSync;

  gpio_port_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  gpio_port_datapath #(.PIN_W(PIN_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (busWdata),
    .padIn   (padIn),
    .rdData  (busRdata),
    .padOut  (padOut),
    .padOe   (padOe),
    .latState(latState),
    .pinSync (pinSync)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int PIN_W  = 16,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [PIN_W-1:0]  busWdata,
  input logic [PIN_W-1:0]  busRdata,
  input logic [PIN_W-1:0]  padIn,
  input logic [PIN_W-1:0]  padOut,
  input logic [PIN_W-1:0]  padOe,
  input logic [PIN_W-1:0]  latState,
  input logic [PIN_W-1:0]  pinSync
);

  logic [1:0] upCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  // R2: bits written as inputs are not enabled after the write
  a_r2_input_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr == 0) |=> ((padOe & $past(busWdata)) == '0));

  // R4: nothing is driven high unless enabled; open-drain never drives 1 undriven
  a_r4_no_undriven_high: assert property (@(posedge clk) disable iff (!rstN)
    (padOut & ~padOe) == '0);

  // R6: port and latch writes store into the latch
  a_r6_latch_store: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && (busAddr == 1 || busAddr == 3)) |=> (latState == $past(busWdata)));

  // R7: synchronizer output lags the pads by two edges
  a_r7_sync_lag: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd3) |-> (pinSync == $past(padIn, 2)));

  // R8: read data holds when no read is accepted
  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWrite) |=> $stable(busRdata));

  // R8: latch read returns the latch one edge later
  a_r8_latch_read: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && busAddr == 1) |=> (busRdata == $past(latState)));

endmodule

bind gpio_port gpio_port_chk #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWrite(busWrite),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .padIn   (padIn),
  .padOut  (padOut),
  .padOe   (padOe),
  .latState(latState),
  .pinSync (pinSync)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busSel = 1'b0;
  logic         busWrite = 1'b0;
  logic [1:0]   busAddr = '0;
  logic [W-1:0] busWdata = '0;
  logic [W-1:0] busRdata;
  logic [W-1:0] padIn = '0;
  logic [W-1:0] padOut;
  logic [W-1:0] padOe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_port u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(logic [1:0] a, logic [W-1:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(logic [1:0] a, output logic [W-1:0] d);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
    d = busRdata;
  endtask

  function automatic logic [W-1:0] nextPat(logic [W-1:0] s);
    logic [W-1:0] x = s;
    x = x ^ (x << 7);
    x = x ^ (x >> 9);
    x = x ^ (x << 8);
    return x;
  endfunction

  task automatic checkPads(logic [W-1:0] dir, logic [W-1:0] od, logic [W-1:0] lat);
    logic [W-1:0] ppMask = ~dir & ~od;
    logic [W-1:0] odMask = ~dir & od;
    check("R2 input oe",  padOe & dir, '0);
    check("R2 input out", padOut & dir, '0);
    check("R3 push-pull oe",  padOe & ppMask, ppMask);
    check("R3 push-pull out", padOut & ppMask, lat & ppMask);
    check("R4 open-drain oe",  padOe & odMask, ~lat & odMask);
    check("R4 open-drain out", padOut & odMask, '0);
  endtask

  task automatic finish();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    logic [W-1:0] rd;
    logic [W-1:0] sDir, sOd, sLat, sPad;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    busRd(2'd0, rd); check("R1 dir reset", rd, '1);
    busRd(2'd1, rd); check("R1 latch reset", rd, '0);
    busRd(2'd2, rd); check("R1 odc reset", rd, '0);
    check("R2 reset oe", padOe, '0);

    // R5: open-drain bits on inputs change nothing
    busWr(2'd1, 16'hFFFF);
    busWr(2'd2, 16'hA5C3);
    check("R5 oe unaffected", padOe, '0);
    check("R5 out unaffected", padOut, '0);
    busWr(2'd2, 16'hFFFF);
    check("R5 oe all-od", padOe, '0);
    check("R5 out all-od", padOut, '0);

    // R6 port write lands in latch, read back via latch address
    busWr(2'd3, 16'h3C5A);
    busRd(2'd1, rd); check("R6 port write to latch", rd, 16'h3C5A);
    busWr(2'd1, 16'h0F0F);
    busRd(2'd1, rd); check("R6 latch write", rd, 16'h0F0F);

    // R9: write takes effect at the accepting edge only
    busWr(2'd2, 16'h0000);
    busWr(2'd1, 16'h00FF);
    busSel = 1'b1; busWrite = 1'b1; busAddr = 2'd0; busWdata = 16'h0000;
    check("R9 before edge", padOe, '0);
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
    check("R9 after edge oe", padOe, 16'hFFFF);
    check("R9 after edge out", padOut, 16'h00FF);

    // R7 port read returns synchronized pads, latch read does not
    padIn = 16'hBEEF;
    @(negedge clk);
    busRd(2'd3, rd); check("R7 one edge is too early", rd, 16'h0000);
    busRd(2'd3, rd); check("R7 port read pads", rd, 16'hBEEF);
    busRd(2'd1, rd); check("R7 latch read not pads", rd, 16'h00FF);
    padIn = 16'h1234;
    @(negedge clk); @(negedge clk);
    busRd(2'd3, rd); check("R7 port read new pads", rd, 16'h1234);

    // R8 read data holds while idle
    repeat (3) @(negedge clk);
    check("R8 hold while idle", busRdata, 16'h1234);
    busWr(2'd1, 16'hFFFF);
    check("R8 hold across write", busRdata, 16'h1234);

    // uniform sweep over every (dir, od, latch) combination
    for (int c = 0; c < 8; c++) begin
      sDir = c[0] ? '1 : '0;
      sOd  = c[1] ? '1 : '0;
      sLat = c[2] ? '1 : '0;
      busWr(2'd0, sDir); busWr(2'd2, sOd); busWr(2'd1, sLat);
      checkPads(sDir, sOd, sLat);
    end

    // mixed-pattern sweep
    sDir = 16'h1D2B; sOd = 16'h7A11; sLat = 16'hC0DE; sPad = 16'h5151;
    for (int i = 0; i < 200; i++) begin
      sDir = nextPat(sDir); sOd = nextPat(sOd); sLat = nextPat(sLat); sPad = nextPat(sPad);
      busWr(2'd0, sDir); busWr(2'd2, sOd);
      if (i[0]) busWr(2'd3, sLat); else busWr(2'd1, sLat);
      checkPads(sDir, sOd, sLat);
      padIn = sPad;
      @(negedge clk); @(negedge clk);
      busRd(2'd3, rd); check("R7 sweep port", rd, sPad);
      busRd(2'd1, rd); check("R6 sweep latch", rd, sLat);
      busRd(2'd0, rd); check("R6 sweep dir", rd, sDir);
      busRd(2'd2, rd); check("R6 sweep odc", rd, sOd);
    end

    finish();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish();
    end
  end

endmodule